// File: doc/BRIEF.md
# Recently-Missed Snoop Exclusion Filter

This block sits between the coherence bus and the tag arrays of a private second-level cache. It remembers block addresses that were snooped recently, were forwarded to the cache, missed there, and have not been brought in since. When a later snoop asks about one of those blocks, the filter answers "definitely not cached" and the cache tag lookup can be skipped. Any other snoop gets the answer "may be cached" and must be forwarded as usual.

The store is set-associative. It has three request ports, each with its own valid strobe:

- **Lookup:** carries the snoop address. It is answered one cycle later.
- **Allocate:** driven by the cache controller after a forwarded snoop missed.
- **Invalidate:** driven whenever a local miss fills a block into the cache. This port keeps the "not cached" guarantee true.

An optional vector mode lets one entry cover a run of `VEC_W` consecutive blocks. Each entry keeps one bit per block. Allocations and invalidations then set or clear single bits instead of whole entries.

The answer is carried by a three-state verdict register:

- **VD_IDLE:** no lookup was made in the previous cycle.
- **VD_ABSENT:** the previous lookup was filtered.
- **VD_MAYBE:** the previous lookup must be forwarded.

Each cycle the verdict moves to VD_IDLE when no lookup is presented, to VD_ABSENT on a filterable lookup, and to VD_MAYBE otherwise.

Top module: `snpx_filter`

## Requirements
- R1: After reset the store holds no entries: every lookup is answered with `rsp_absent`=0, and `rsp_valid` is 0 in any cycle that does not follow a lookup.
- R2: A lookup presented in cycle k is answered in cycle k+1 with `rsp_valid`=1. `rsp_absent` is never 1 while `rsp_valid` is 0.
- R3: A block allocated in cycle k, with no invalidate in that cycle, is reported absent (`rsp_absent`=1) by any lookup from cycle k+1 on, until it is invalidated or its entry is replaced.
- R4: A lookup of a block that was never allocated, or of a block whose tag differs from every stored tag in its set, is answered with `rsp_absent`=0.
- R5: An invalidate clears only the addressed block's bit. Other blocks held by the same entry stay reported absent.
- R6: In vector mode, the block address splits into three fields. The low log2(`VEC_W`) bits select the vector bit (bit i means block chunk*`VEC_W`+i). The next log2(`SETS`) bits give the set. The remaining upper bits form the tag. Allocating into a chunk that already has an entry sets one more bit in that entry and uses no other way. A new entry starts with only its allocating bit set.
- R7: An entry whose vector becomes all zero is free. A new entry goes into the lowest-numbered free way of its set before any valid entry is replaced.
- R8: With more than two ways and no free way, the victim is chosen by a binary pseudo-LRU tree of `WAYS`-1 bits per set. Every allocation (new or merged) makes each node on the used way's path point to the other half. The victim is found by following the pointers from the root (0 means the lower half).
- R9: With two ways and no free way, the victim is taken from a per-set round-robin pointer. After each new entry the pointer moves to the way not just written. Merges do not move it.
- R10: If an invalidate and a lookup of the same block occur in the same cycle, the lookup is answered with `rsp_absent`=0.
- R11: An allocate presented in the same cycle as any invalidate is dropped, so a later lookup of that block reports `rsp_absent`=0 unless it was already held.
- R12: With `VEC_W`=1, each entry covers exactly one block. Allocating a block leaves its neighbours and set-mates with other tags unfiltered.
- R13: A lookup in the same cycle as an allocate of the same block sees the store before that allocate and reports `rsp_absent`=0 for a block not yet held. A lookup one cycle later reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Snoop lookup request strobe |
| lk_addr | input | ADDR_W | Block address of the snoop |
| al_valid | input | 1 | Allocate strobe: a forwarded snoop missed in the cache |
| al_addr | input | ADDR_W | Block address to record as absent |
| iv_valid | input | 1 | Invalidate strobe: a local miss fills a block |
| iv_addr | input | ADDR_W | Block address being filled |
| rsp_valid | output | 1 | Lookup answer valid, one cycle after `lk_valid` |
| rsp_absent | output | 1 | 1: block is guaranteed not cached; 0: forward the snoop |

## Verification
There are two kinds of internal fault, and they look different at the ports.

- **Corrupt entry or dropped invalidate.** This is the dangerous case. It shows up as `rsp_absent`=1 for a block the cache holds. It appears on the very next lookup of that block, one cycle after the request.
- **Wrong replacement choice or lost merge.** This is only a loss of filtering. It shows up later, when a block expected to be held is answered with `rsp_absent`=0. That can happen many cycles after the faulty allocation.

The bench runs a behavioural model next to the design and compares both outputs every cycle. It does this for two geometries at once (vector plus pseudo-LRU, and plain plus round-robin), so either kind of fault is reported on the first lookup that exposes it.

// File: rtl/snpx_pkg.sv
package snpx_pkg;

    // Registered answer to a lookup made in the previous cycle.
    typedef enum logic [1:0] {
        VD_IDLE   = 2'd0,
        VD_ABSENT = 2'd1,
        VD_MAYBE  = 2'd2
    } verdict_e;

endpackage

// File: rtl/snpx_addr_split.sv
// Splits a block address into vector select, set index and tag.
module snpx_addr_split #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int VEC_W  = 4,
    parameter int VBITS  = $clog2(VEC_W),
    parameter int SBITS  = $clog2(SETS),
    parameter int SEL_W  = (VEC_W > 1) ? VBITS : 1,
    parameter int TAG_W  = ADDR_W - VBITS - SBITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SBITS-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag,
    output logic [SEL_W-1:0]  sel
);
    logic [ADDR_W-VBITS-1:0] chunk;

    generate
        if (VEC_W > 1) begin : g_vec
            assign chunk = addr[ADDR_W-1:VBITS];
            assign sel   = addr[VBITS-1:0];
        end else begin : g_plain
            assign chunk = addr;
            assign sel   = '0;
        end
    endgenerate

    assign set_idx = chunk[SBITS-1:0];
    assign tag     = chunk[ADDR_W-VBITS-1:SBITS];
endmodule

// File: rtl/snpx_entry_store.sv
// Tag and vector storage: two combinational read ports, one write port.
module snpx_entry_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    parameter int VEC_W = 4,
    parameter int SBITS = $clog2(SETS),
    parameter int WBITS = $clog2(WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SBITS-1:0]               a_set,
    output logic [WAYS-1:0][TAG_W-1:0]     a_tags,
    output logic [WAYS-1:0][VEC_W-1:0]     a_vecs,
    input  logic [SBITS-1:0]               b_set,
    output logic [WAYS-1:0][TAG_W-1:0]     b_tags,
    output logic [WAYS-1:0][VEC_W-1:0]     b_vecs,
    input  logic                           wr_en,
    input  logic [SBITS-1:0]               wr_set,
    input  logic [WBITS-1:0]               wr_way,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [VEC_W-1:0]               wr_vec
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [VEC_W-1:0] vec_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    vec_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            vec_q[wr_set][wr_way] <= wr_vec;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            a_tags[w] = tag_q[a_set][w];
            a_vecs[w] = vec_q[a_set][w];
            b_tags[w] = tag_q[b_set][w];
            b_vecs[w] = vec_q[b_set][w];
        end
    end
endmodule

// File: rtl/snpx_way_match.sv
// Compares one set's ways against a tag; also finds the lowest free way.
module snpx_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    parameter int VEC_W = 4,
    parameter int WBITS = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0][VEC_W-1:0] vecs,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit_any,
    output logic [WBITS-1:0]           hit_idx,
    output logic [VEC_W-1:0]           hit_vec,
    output logic                       free_any,
    output logic [WBITS-1:0]           free_idx
);
    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        hit_vec  = '0;
        free_any = 1'b0;
        free_idx = '0;
        // Descending scan so the lowest-numbered free way wins.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vecs[w] != '0 && tags[w] == tag) begin
                hit_any = 1'b1;
                hit_idx = WBITS'(w);
                hit_vec = vecs[w];
            end
            if (vecs[w] == '0) begin
                free_any = 1'b1;
                free_idx = WBITS'(w);
            end
        end
    end
endmodule

// File: rtl/snpx_repl.sv
// Per-set victim choice: round-robin for two ways, pseudo-LRU tree otherwise.
module snpx_repl #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int SBITS = $clog2(SETS),
    parameter int WBITS = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SBITS-1:0] set_idx,
    input  logic             touch,
    input  logic             fresh,
    input  logic [WBITS-1:0] touch_way,
    output logic [WBITS-1:0] victim
);
    generate
        if (WAYS == 2) begin : g_rr
            logic ptr_q [SETS];
            logic unused_touch;
            assign unused_touch = touch;
            assign victim = ptr_q[set_idx];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) ptr_q[s] <= 1'b0;
                end else if (fresh) begin
                    ptr_q[set_idx] <= ~touch_way[0];
                end
            end
        end else begin : g_tree
            logic [WAYS-2:0] tree_q [SETS];
            logic [WAYS-2:0] cur_bits, nxt_bits;
            logic unused_fresh;
            assign unused_fresh = fresh;

            always_comb begin
                int node;
                cur_bits = tree_q[set_idx];
                node = 0;
                for (int l = 0; l < WBITS; l++) begin
                    node = 2 * node + 1 + (cur_bits[node] ? 1 : 0);
                end
                victim = WBITS'(node - (WAYS - 1));
                nxt_bits = cur_bits;
                node = 0;
                for (int l = WBITS - 1; l >= 0; l--) begin
                    nxt_bits[node] = ~touch_way[l];
                    node = 2 * node + 1 + (touch_way[l] ? 1 : 0);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
                end else if (touch) begin
                    tree_q[set_idx] <= nxt_bits;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/snpx_filter.sv
module snpx_filter
    import snpx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int VEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              al_valid,
    input  logic [ADDR_W-1:0] al_addr,
    input  logic              iv_valid,
    input  logic [ADDR_W-1:0] iv_addr,
    output logic              rsp_valid,
    output logic              rsp_absent
);
    localparam int SBITS = $clog2(SETS);
    localparam int WBITS = $clog2(WAYS);
    localparam int VBITS = $clog2(VEC_W);
    localparam int SEL_W = (VEC_W > 1) ? VBITS : 1;
    localparam int TAG_W = ADDR_W - VBITS - SBITS;

    logic [SBITS-1:0] lk_set, up_set;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [SEL_W-1:0] lk_sel, up_sel;
    logic [ADDR_W-1:0] up_addr;

    logic [WAYS-1:0][TAG_W-1:0] lk_tags, up_tags;
    logic [WAYS-1:0][VEC_W-1:0] lk_vecs, up_vecs;

    logic             lk_hit, up_hit, up_free;
    logic [VEC_W-1:0] lk_hvec, up_hvec;
    logic [WBITS-1:0] up_hidx, up_fidx, victim;
    logic             unused_lk_free;
    logic [WBITS-1:0] unused_lk_hidx, unused_lk_fidx;

    logic             wr_en, touch, fresh;
    logic [WBITS-1:0] wr_way;
    logic [VEC_W-1:0] wr_vec, up_oh, lk_oh;
    logic             lk_filter;

    verdict_e vd_q, vd_d;

    // Invalidate owns the update path whenever it is present.
    assign up_addr = iv_valid ? iv_addr : al_addr;

    snpx_addr_split #(.ADDR_W(ADDR_W), .SETS(SETS), .VEC_W(VEC_W)) lk_split_i (
        .addr(lk_addr), .set_idx(lk_set), .tag(lk_tag), .sel(lk_sel));
    snpx_addr_split #(.ADDR_W(ADDR_W), .SETS(SETS), .VEC_W(VEC_W)) up_split_i (
        .addr(up_addr), .set_idx(up_set), .tag(up_tag), .sel(up_sel));

    snpx_entry_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .VEC_W(VEC_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .a_set(lk_set), .a_tags(lk_tags), .a_vecs(lk_vecs),
        .b_set(up_set), .b_tags(up_tags), .b_vecs(up_vecs),
        .wr_en(wr_en), .wr_set(up_set), .wr_way(wr_way),
        .wr_tag(up_tag), .wr_vec(wr_vec));

    snpx_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .VEC_W(VEC_W)) lk_match_i (
        .tags(lk_tags), .vecs(lk_vecs), .tag(lk_tag),
        .hit_any(lk_hit), .hit_idx(unused_lk_hidx), .hit_vec(lk_hvec),
        .free_any(unused_lk_free), .free_idx(unused_lk_fidx));

    snpx_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .VEC_W(VEC_W)) up_match_i (
        .tags(up_tags), .vecs(up_vecs), .tag(up_tag),
        .hit_any(up_hit), .hit_idx(up_hidx), .hit_vec(up_hvec),
        .free_any(up_free), .free_idx(up_fidx));

    snpx_repl #(.SETS(SETS), .WAYS(WAYS)) repl_i (
        .clk(clk), .rst_n(rst_n), .set_idx(up_set),
        .touch(touch), .fresh(fresh), .touch_way(wr_way), .victim(victim));

    assign up_oh = VEC_W'(1) << up_sel;
    assign lk_oh = VEC_W'(1) << lk_sel;

    // Update path: invalidate clears one bit, allocate merges or installs.
    always_comb begin
        wr_en  = 1'b0;
        wr_way = up_hidx;
        wr_vec = '0;
        touch  = 1'b0;
        fresh  = 1'b0;
        if (iv_valid) begin
            if (up_hit) begin
                wr_en  = 1'b1;
                wr_vec = up_hvec & ~up_oh;
            end
        end else if (al_valid) begin
            wr_en = 1'b1;
            touch = 1'b1;
            if (up_hit) begin
                wr_vec = up_hvec | up_oh;
            end else begin
                fresh  = 1'b1;
                wr_way = up_free ? up_fidx : victim;
                wr_vec = up_oh;
            end
        end
    end

    // A same-cycle fill of the looked-up block overrides a stored hit.
    assign lk_filter = lk_hit && ((lk_hvec & lk_oh) != '0)
                       && !(iv_valid && iv_addr == lk_addr);

    always_comb begin
        if (!lk_valid)      vd_d = VD_IDLE;
        else if (lk_filter) vd_d = VD_ABSENT;
        else                vd_d = VD_MAYBE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= VD_IDLE;
        else        vd_q <= vd_d;
    end

    always_comb begin
        unique case (vd_q)
            VD_IDLE: begin
                rsp_valid  = 1'b0;
                rsp_absent = 1'b0;
            end
            VD_ABSENT: begin
                rsp_valid  = 1'b1;
                rsp_absent = 1'b1;
            end
            VD_MAYBE: begin
                rsp_valid  = 1'b1;
                rsp_absent = 1'b0;
            end
            default: begin
                rsp_valid  = 1'b0;
                rsp_absent = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/snpx_filter_chk.sv
module snpx_filter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic              al_valid,
    input logic [ADDR_W-1:0] al_addr,
    input logic              iv_valid,
    input logic [ADDR_W-1:0] iv_addr,
    input logic              rsp_valid,
    input logic              rsp_absent
);
    // R2: every lookup is answered in the next cycle
    a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2: no answer without a lookup in the previous cycle
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    // R1: absent is only reported together with a valid answer
    a_r1_absent_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_absent |-> rsp_valid);

    // R10: a same-cycle fill of the looked-up block forces "may be cached"
    a_r10_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && iv_valid && lk_addr == iv_addr) |=> !rsp_absent);

    // R3: an accepted allocate is visible to a lookup in the following cycle
    a_r3_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (al_valid && !iv_valid) ##1 (lk_valid && !iv_valid && lk_addr == $past(al_addr))
        |=> rsp_absent);
endmodule

bind snpx_filter snpx_filter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .al_valid(al_valid), .al_addr(al_addr),
    .iv_valid(iv_valid), .iv_addr(iv_addr),
    .rsp_valid(rsp_valid), .rsp_absent(rsp_absent));

// File: tb/snpx_filter_ref.sv
// Behavioural reference: per-set entry lists and replacement state in integers.
module snpx_filter_ref #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 32,
    parameter int WAYS   = 4,
    parameter int VEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              al_valid,
    input  logic [ADDR_W-1:0] al_addr,
    input  logic              iv_valid,
    input  logic [ADDR_W-1:0] iv_addr,
    output logic              exp_valid,
    output logic              exp_absent
);
    localparam int LV = $clog2(WAYS);

    longint unsigned m_tag  [SETS][WAYS];
    int unsigned     m_bits [SETS][WAYS];
    int              m_tree [SETS][WAYS];
    int              m_ptr  [SETS];

    function automatic void split(input logic [ADDR_W-1:0] a, output int s,
                                  output longint unsigned t, output int b);
        longint unsigned blk = longint'(a);
        b   = int'(blk % VEC_W);
        blk = blk / VEC_W;
        s   = int'(blk % SETS);
        t   = blk / SETS;
    endfunction

    function automatic int find(input int s, input longint unsigned t);
        for (int w = 0; w < WAYS; w++)
            if (m_bits[s][w] != 0 && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic void touch(input int s, input int w);
        int node = 0;
        for (int l = LV - 1; l >= 0; l--) begin
            int d = (w >> l) & 1;
            m_tree[s][node] = 1 - d;
            node = 2 * node + 1 + d;
        end
    endfunction

    function automatic int pick(input int s);
        int node = 0;
        for (int w = 0; w < WAYS; w++) if (m_bits[s][w] == 0) return w;
        if (WAYS == 2) return m_ptr[s];
        for (int l = 0; l < LV; l++) node = 2 * node + 1 + m_tree[s][node];
        return node - (WAYS - 1);
    endfunction

    always @(posedge clk) begin
        int s, b, w;
        longint unsigned t;
        bit hit;
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                m_ptr[i] = 0;
                for (int j = 0; j < WAYS; j++) begin
                    m_tag[i][j] = 0; m_bits[i][j] = 0; m_tree[i][j] = 0;
                end
            end
            exp_valid  <= 1'b0;
            exp_absent <= 1'b0;
        end else begin
            hit = 1'b0;
            if (lk_valid) begin
                split(lk_addr, s, t, b);
                w = find(s, t);
                if (w >= 0 && ((m_bits[s][w] >> b) & 1) == 1) hit = 1'b1;
                if (iv_valid && iv_addr == lk_addr) hit = 1'b0;
            end
            exp_valid  <= lk_valid;
            exp_absent <= hit;
            if (iv_valid) begin
                split(iv_addr, s, t, b);
                w = find(s, t);
                if (w >= 0) m_bits[s][w] = m_bits[s][w] & ~(32'd1 << b);
            end else if (al_valid) begin
                split(al_addr, s, t, b);
                w = find(s, t);
                if (w >= 0) begin
                    m_bits[s][w] = m_bits[s][w] | (32'd1 << b);
                end else begin
                    w = pick(s);
                    m_tag[s][w]  = t;
                    m_bits[s][w] = 32'd1 << b;
                    m_ptr[s]     = 1 - w;
                end
                touch(s, w);
            end
        end
    end
endmodule

// File: tb/snpx_filter_tb_top.sv
module snpx_filter_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_v = 1'b0, al_v = 1'b0, iv_v = 1'b0;
    logic [31:0] lk_a = '0, al_a = '0, iv_a = '0;
    logic        rv_a, ra_a, rv_b, ra_b;
    logic        ev_a, ea_a, ev_b, ea_b;
    int          n_chk = 0, n_fail = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    // Vector mode, 32 sets x 4 ways, pseudo-LRU (default geometry)
    snpx_filter dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_addr(lk_a),
        .al_valid(al_v), .al_addr(al_a), .iv_valid(iv_v), .iv_addr(iv_a),
        .rsp_valid(rv_a), .rsp_absent(ra_a));
    snpx_filter_ref ref_a_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_addr(lk_a),
        .al_valid(al_v), .al_addr(al_a), .iv_valid(iv_v), .iv_addr(iv_a),
        .exp_valid(ev_a), .exp_absent(ea_a));

    // Plain mode (R12), 8 sets x 2 ways, round-robin (R9)
    snpx_filter #(.SETS(8), .WAYS(2), .VEC_W(1)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_addr(lk_a),
        .al_valid(al_v), .al_addr(al_a), .iv_valid(iv_v), .iv_addr(iv_a),
        .rsp_valid(rv_b), .rsp_absent(ra_b));
    snpx_filter_ref #(.SETS(8), .WAYS(2), .VEC_W(1)) ref_b_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_v), .lk_addr(lk_a),
        .al_valid(al_v), .al_addr(al_a), .iv_valid(iv_v), .iv_addr(iv_a),
        .exp_valid(ev_b), .exp_absent(ea_b));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "vec/plru rsp_valid vs model", rv_a, ev_a);
            check(cur_req, "vec/plru rsp_absent vs model", ra_a, ea_a);
            check(cur_req, "plain/rr rsp_valid vs model", rv_b, ev_b);
            check(cur_req, "plain/rr rsp_absent vs model", ra_b, ea_b);
        end
    end

    function automatic logic [31:0] mk(input int tag, input int set, input int sel);
        return 32'((tag << 7) | (set << 2) | sel);
    endfunction

    task automatic cyc(input logic lv, input logic [31:0] la, input logic av,
                       input logic [31:0] aa, input logic iv, input logic [31:0] ia);
        lk_v = lv; lk_a = la; al_v = av; al_a = aa; iv_v = iv; iv_a = ia;
        @(posedge clk); #1;
        lk_v = 1'b0; al_v = 1'b0; iv_v = 1'b0;
    endtask

    task automatic alloc(input logic [31:0] a);
        cyc(1'b0, '0, 1'b1, a, 1'b0, '0);
    endtask

    task automatic inval(input logic [31:0] a);
        cyc(1'b0, '0, 1'b0, '0, 1'b1, a);
    endtask

    // Answer of both instances to the request just sampled, hand-computed.
    task automatic expect_rsp(input string req, input logic exp_a, input logic exp_b);
        check(req, "vec/plru answer valid", rv_a, 1'b1);
        check(req, "vec/plru answer", ra_a, exp_a);
        check(req, "plain/rr answer valid", rv_b, 1'b1);
        check(req, "plain/rr answer", ra_b, exp_b);
    endtask

    task automatic look(input logic [31:0] a, input logic exp_a, input logic exp_b, input string req);
        cyc(1'b1, a, 1'b0, '0, 1'b0, '0);
        expect_rsp(req, exp_a, exp_b);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset, idle answers invalid
        cur_req = "R1";
        check("R1", "idle rsp_valid", rv_a, 1'b0);
        check("R1", "idle rsp_valid plain", rv_b, 1'b0);
        look(mk(1, 1, 1), 1'b0, 1'b0, "R1");
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        check("R2", "no answer after idle cycle", rv_a, 1'b0);

        // R3 / R4
        cur_req = "R3";
        alloc(mk(3, 4, 1));
        look(mk(3, 4, 1), 1'b1, 1'b1, "R3");
        cur_req = "R4";
        look(mk(3, 5, 1), 1'b0, 1'b0, "R4");

        // R6 merge and fresh-entry bits, R5 single-bit invalidate
        cur_req = "R6";
        alloc(mk(6, 10, 1));
        look(mk(6, 10, 2), 1'b0, 1'b0, "R6");
        alloc(mk(6, 10, 2));
        look(mk(6, 10, 1), 1'b1, 1'b1, "R6");
        look(mk(6, 10, 2), 1'b1, 1'b1, "R6");
        cur_req = "R5";
        inval(mk(6, 10, 1));
        look(mk(6, 10, 1), 1'b0, 1'b0, "R5");
        look(mk(6, 10, 2), 1'b1, 1'b1, "R5");

        // R10: fill and lookup of the same block together
        cur_req = "R10";
        alloc(mk(2, 20, 3));
        cyc(1'b1, mk(2, 20, 3), 1'b0, '0, 1'b1, mk(2, 20, 3));
        expect_rsp("R10", 1'b0, 1'b0);
        look(mk(2, 20, 3), 1'b0, 1'b0, "R10");

        // R13: lookup sees store before a same-cycle allocate
        cur_req = "R13";
        cyc(1'b1, mk(2, 21, 0), 1'b1, mk(2, 21, 0), 1'b0, '0);
        expect_rsp("R13", 1'b0, 1'b0);
        look(mk(2, 21, 0), 1'b1, 1'b1, "R13");

        // R11: allocate dropped under a concurrent invalidate
        cur_req = "R11";
        cyc(1'b0, '0, 1'b1, mk(2, 22, 1), 1'b1, mk(1, 1, 0));
        look(mk(2, 22, 1), 1'b0, 1'b0, "R11");

        // R8: pseudo-LRU victim order in one set
        cur_req = "R8";
        for (int t = 1; t <= 6; t++) alloc(mk(t, 5, 0));
        look(mk(1, 5, 0), 1'b0, 1'b0, "R8");
        look(mk(2, 5, 0), 1'b1, 1'b0, "R8");
        look(mk(3, 5, 0), 1'b0, 1'b0, "R8");
        look(mk(4, 5, 0), 1'b1, 1'b0, "R8");
        look(mk(5, 5, 0), 1'b1, 1'b1, "R8");
        look(mk(6, 5, 0), 1'b1, 1'b1, "R8");

        // R7: freed way reused before any eviction
        cur_req = "R7";
        for (int t = 1; t <= 4; t++) alloc(mk(t, 9, 2));
        inval(mk(2, 9, 2));
        alloc(mk(7, 9, 2));
        look(mk(1, 9, 2), 1'b1, 1'b0, "R7");
        look(mk(2, 9, 2), 1'b0, 1'b0, "R7");
        look(mk(3, 9, 2), 1'b1, 1'b0, "R7");
        look(mk(4, 9, 2), 1'b1, 1'b1, "R7");
        look(mk(7, 9, 2), 1'b1, 1'b1, "R7");

        // R9: round-robin in the two-way instance
        cur_req = "R9";
        alloc(32'd15);
        alloc(32'd47);
        alloc(32'd79);
        look(32'd15, 1'b1, 1'b0, "R9");
        look(32'd47, 1'b1, 1'b1, "R9");
        look(32'd79, 1'b1, 1'b1, "R9");

        // R12: plain mode covers one block per entry
        cur_req = "R12";
        alloc(mk(4, 12, 0));
        look(mk(4, 12, 1), 1'b0, 1'b0, "R12");
        look(mk(4, 14, 0), 1'b0, 1'b0, "R12");
        look(mk(4, 12, 0), 1'b1, 1'b1, "R12");

        // Mixed traffic over a small address space, model compared each clock
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a1, a2, a3;
            a1 = mk(int'($urandom_range(5)), int'($urandom_range(1)), int'($urandom_range(3)));
            a2 = mk(int'($urandom_range(5)), int'($urandom_range(1)), int'($urandom_range(3)));
            a3 = ($urandom_range(3) == 0) ? a1
                 : mk(int'($urandom_range(5)), int'($urandom_range(1)), int'($urandom_range(3)));
            cyc(1'($urandom_range(1)), a1, 1'($urandom_range(1)), a2,
                ($urandom_range(3) == 0), a3);
        end

        repeat (2) @(posedge clk);
        #1 finish_run();
    end
endmodule